// File: doc/BRIEF.md
# Masked Configuration Control Register

This block is the main control word of a configuration controller. Two register ports reach it: an external configuration port, which is subject to a security level, and an internal configuration port, which is never restricted. A second register, the write mask, decides which control bits a control-word write may change. Software can therefore flip a single control bit, such as the global I/O enable, without restating the others.

The block decodes the control word into the key source select, the internal port select, the over-temperature shutdown enable, the fallback disable, the active-low readback mask, the decryptor enable, the persist flag and the active-low global I/O tristate. The first time the decryptor enable is set, the key source is captured and frozen. A written security level only waits as a pending value. It is copied into the effective level after the end-of-load pulse when the current load is encrypted, or after the end-of-startup pulse when it is not. The effective level then gates external reads and writes. A blocked access produces a one-cycle reject strobe and returns zero data.

Top module: `cfgctl_reg`

## Requirements
- R1: After reset the control word reads 0x00000101, the mask reads 0, the effective security level is 00, and both read data outputs and the reject strobe are 0.
- R2: A write to address 6 stores all data bits into the mask. A write to address 5 changes only the control bits whose mask bit is 1. Every other control bit keeps its value.
- R3: Only bits 31, 30, 12, 10, 8, 6, 5, 4, 3 and 0 of the control word are storable. All other bits read 0 for any mask value.
- R4: The outputs follow the stored control bits. port_sel is bit 30, ot_shutdown_en is bit 12, fallback_dis is bit 10, readback_mask_n is bit 8, decrypt_en is bit 6, persist is bit 3 and io_tristate_n is bit 0.
- R5: key_src follows bit 31 until the first write that changes bit 6 from 0 to 1. That write's bit 31 is captured, and key_src holds it until reset, even though bit 31 stays readable and writable.
- R6: Bits 5:4 form a pending level. With enc_load high it becomes the effective sec_level one cycle after a load_done pulse. With enc_load low it does so one cycle after a startup_done pulse. At no other time does sec_level change.
- R7: An external read while sec_level is not 00 returns 0, and ext_reject is 1 in the following cycle.
- R8: While sec_level is 10 or 11, every external write is discarded and raises ext_reject in the following cycle.
- R9: While enc_load is high at levels 00 and 01, external writes are accepted only for addresses 1 and 2. Any other external write, including one to addresses 5 or 6, is discarded and rejected.
- R10: The internal port is never restricted by sec_level or enc_load. ext_reject is raised only by an external access.
- R11: When both ports write in one cycle and the internal write targets address 5 or 6, only the internal write takes effect.
- R12: Read data appears one cycle after the read request. It shows the register value from before any write in the same cycle. Reads of addresses other than 5 and 6 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rd_en | input | 1 | External port read request |
| ext_wr_en | input | 1 | External port write request |
| ext_addr | input | ADDR_W | External port register address |
| ext_wdata | input | DATA_W | External port write data |
| ext_rdata | output | DATA_W | External port read data, one cycle later |
| ext_reject | output | 1 | One-cycle strobe for a blocked external access |
| int_rd_en | input | 1 | Internal port read request |
| int_wr_en | input | 1 | Internal port write request |
| int_addr | input | ADDR_W | Internal port register address |
| int_wdata | input | DATA_W | Internal port write data |
| int_rdata | output | DATA_W | Internal port read data, one cycle later |
| enc_load | input | 1 | High while the current load is encrypted |
| load_done | input | 1 | Single-cycle end-of-encrypted-load pulse |
| startup_done | input | 1 | Single-cycle end-of-startup pulse |
| key_src | output | 1 | Effective key source (0 battery RAM, 1 fuse) |
| port_sel | output | 1 | Internal port select (0 top, 1 bottom) |
| ot_shutdown_en | output | 1 | Over-temperature shutdown enable |
| fallback_dis | output | 1 | Disables fallback to the default image |
| readback_mask_n | output | 1 | Active-low mask of changeable-cell readback |
| decrypt_en | output | 1 | Decryptor enable |
| sec_level | output | 2 | Effective security level |
| persist | output | 1 | Keep the configuration interface after load |
| io_tristate_n | output | 1 | Active-low global I/O tristate |

## Verification
The properties assume that load_done and startup_done are single-cycle pulses, and that inputs stay idle during the two cycles in which the internal reset is released. They also assume that only the ports listed above drive the block, so the effective level moves only after a qualifying pulse. The stimulus holds every request and pulse for exactly one clock and waits several idle cycles after reset. The random phase draws addresses from the control, mask, frame and unused ranges while enc_load and the pulses toggle. Internal writes keep lowering the level again, so external traffic is tested at every security level.

// File: rtl/cfgctl_pkg.sv
package cfgctl_pkg;
  localparam int CFG_W = 32;

  // control word bit positions (decoded by neighbours)
  localparam int KEY_B  = 31;
  localparam int PSEL_B = 30;
  localparam int OTS_B  = 12;
  localparam int NOFB_B = 10;
  localparam int RBK_B  = 8;
  localparam int DEC_B  = 6;
  localparam int SECH_B = 5;
  localparam int SECL_B = 4;
  localparam int PER_B  = 3;
  localparam int IOEN_B = 0;

  localparam logic [CFG_W-1:0] STORE_BITS = 32'hC000_1579;
  localparam logic [CFG_W-1:0] CTRL_RST   = 32'h0000_0101;

  // register addresses
  localparam int A_FADDR = 1;
  localparam int A_FDATA = 2;
  localparam int A_CTRL  = 5;
  localparam int A_MASK  = 6;

  typedef enum logic [1:0] {
    SEC_OPEN = 2'b00,
    SEC_NORB = 2'b01,
    SEC_LOCK = 2'b10,
    SEC_LCK2 = 2'b11
  } sec_lvl_t;
endpackage

// File: rtl/cfgctl_port_gate.sv
module cfgctl_port_gate
  import cfgctl_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [1:0]        sec_eff,
  input  logic              enc_load,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              reject
);
  logic frame_hit;

  always_comb begin
    frame_hit = (addr == ADDR_W'(A_FADDR)) || (addr == ADDR_W'(A_FDATA));
    rd_ok     = (sec_eff == SEC_OPEN);
    wr_ok     = !sec_eff[1] && (!enc_load || frame_hit);
    reject    = (rd_en && !rd_ok) || (wr_en && !wr_ok);
  end
endmodule

// File: rtl/cfgctl_sec_stage.sv
module cfgctl_sec_stage (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sec_pend,
  input  logic       enc_load,
  input  logic       load_done,
  input  logic       startup_done,
  output logic [1:0] sec_eff
);
  logic       take;
  logic [1:0] sec_q;

  always_comb take = enc_load ? load_done : startup_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 2'b00;
    end else if (take) begin
      sec_q <= sec_pend;
    end
  end

  assign sec_eff = sec_q;
endmodule

// File: rtl/cfgctl_masked_reg.sv
module cfgctl_masked_reg
  import cfgctl_pkg::*;
#(
  parameter int DATA_W = CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              key_eff
);
  localparam logic [DATA_W-1:0] STORE = DATA_W'(STORE_BITS);
  localparam logic [DATA_W-1:0] CRST  = DATA_W'(CTRL_RST);

  logic [DATA_W-1:0] wsel;
  logic [DATA_W-1:0] ctrl_d;
  logic              frz_q, frz_d;
  logic              klat_q, klat_d;

  always_comb begin
    wsel   = mask_q & STORE;
    ctrl_d = (ctrl_q & ~wsel) | (wdata & wsel);
    frz_d  = frz_q;
    klat_d = klat_q;
    if (wr_ctrl && !frz_q && !ctrl_q[DEC_B] && ctrl_d[DEC_B]) begin
      frz_d  = 1'b1;
      klat_d = ctrl_d[KEY_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CRST;
      mask_q <= '0;
      frz_q  <= 1'b0;
      klat_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_mask) mask_q <= wdata;
      frz_q  <= frz_d;
      klat_q <= klat_d;
    end
  end

  assign key_eff = frz_q ? klat_q : ctrl_q[KEY_B];
endmodule

// File: rtl/cfgctl_reg.sv
module cfgctl_reg
  import cfgctl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = CFG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rd_en,
  input  logic              ext_wr_en,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic [DATA_W-1:0] ext_rdata,
  output logic              ext_reject,
  input  logic              int_rd_en,
  input  logic              int_wr_en,
  input  logic [ADDR_W-1:0] int_addr,
  input  logic [DATA_W-1:0] int_wdata,
  output logic [DATA_W-1:0] int_rdata,
  input  logic              enc_load,
  input  logic              load_done,
  input  logic              startup_done,
  output logic              key_src,
  output logic              port_sel,
  output logic              ot_shutdown_en,
  output logic              fallback_dis,
  output logic              readback_mask_n,
  output logic              decrypt_en,
  output logic [1:0]        sec_level,
  output logic              persist,
  output logic              io_tristate_n
);
  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] AC = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AM = ADDR_W'(A_MASK);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [DATA_W-1:0] ctrl_q, mask_q;
  logic [1:0]        sec_eff;
  logic              e_rd_ok, e_wr_ok, e_rej;
  logic              int_claim, ext_take;
  logic              wr_ctrl, wr_mask;
  logic [DATA_W-1:0] wdata;

  cfgctl_port_gate #(.ADDR_W(ADDR_W)) u_gate (
    .sec_eff  (sec_eff),
    .enc_load (enc_load),
    .rd_en    (ext_rd_en),
    .wr_en    (ext_wr_en),
    .addr     (ext_addr),
    .rd_ok    (e_rd_ok),
    .wr_ok    (e_wr_ok),
    .reject   (e_rej)
  );

  // write arbitration: the internal port wins a same-cycle collision
  always_comb begin
    int_claim = int_wr_en && ((int_addr == AC) || (int_addr == AM));
    ext_take  = !int_claim && ext_wr_en && e_wr_ok &&
                ((ext_addr == AC) || (ext_addr == AM));
    wr_ctrl   = (int_claim && (int_addr == AC)) || (ext_take && (ext_addr == AC));
    wr_mask   = (int_claim && (int_addr == AM)) || (ext_take && (ext_addr == AM));
    wdata     = int_claim ? int_wdata : ext_wdata;
  end

  cfgctl_masked_reg #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_ctrl (wr_ctrl),
    .wr_mask (wr_mask),
    .wdata   (wdata),
    .ctrl_q  (ctrl_q),
    .mask_q  (mask_q),
    .key_eff (key_src)
  );

  cfgctl_sec_stage u_sec (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .sec_pend     (ctrl_q[SECH_B:SECL_B]),
    .enc_load     (enc_load),
    .load_done    (load_done),
    .startup_done (startup_done),
    .sec_eff      (sec_eff)
  );

  // read paths, one per port
  logic              rd_req [NPORT];
  logic              rd_ok  [NPORT];
  logic [ADDR_W-1:0] rd_adr [NPORT];
  logic [DATA_W-1:0] rd_q   [NPORT];

  always_comb begin
    rd_req[0] = ext_rd_en;  rd_ok[0] = e_rd_ok; rd_adr[0] = ext_addr;
    rd_req[1] = int_rd_en;  rd_ok[1] = 1'b1;    rd_adr[1] = int_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    logic [DATA_W-1:0] rd_d;
    always_comb begin
      rd_d = '0;
      if (rd_req[p] && rd_ok[p]) begin
        if (rd_adr[p] == AC)      rd_d = ctrl_q;
        else if (rd_adr[p] == AM) rd_d = mask_q;
      end
    end
    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n) rd_q[p] <= '0;
      else          rd_q[p] <= rd_d;
    end
  end

  logic rej_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) rej_q <= 1'b0;
    else          rej_q <= e_rej;
  end

  assign ext_rdata       = rd_q[0];
  assign int_rdata       = rd_q[1];
  assign ext_reject      = rej_q;
  assign port_sel        = ctrl_q[PSEL_B];
  assign ot_shutdown_en  = ctrl_q[OTS_B];
  assign fallback_dis    = ctrl_q[NOFB_B];
  assign readback_mask_n = ctrl_q[RBK_B];
  assign decrypt_en      = ctrl_q[DEC_B];
  assign persist         = ctrl_q[PER_B];
  assign io_tristate_n   = ctrl_q[IOEN_B];
  assign sec_level       = sec_eff;
endmodule

// File: rtl/cfgctl_reg_chk.sv
module cfgctl_reg_chk
  import cfgctl_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = CFG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_rd_en,
  input logic              ext_wr_en,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              int_rd_en,
  input logic              int_wr_en,
  input logic [ADDR_W-1:0] int_addr,
  input logic [DATA_W-1:0] ext_rdata,
  input logic [DATA_W-1:0] int_rdata,
  input logic              ext_reject,
  input logic              enc_load,
  input logic              load_done,
  input logic              startup_done,
  input logic              key_src,
  input logic              port_sel,
  input logic              decrypt_en,
  input logic [1:0]        sec_level,
  input logic              persist,
  input logic              io_tristate_n
);
  localparam logic [DATA_W-1:0] RSV = ~DATA_W'(STORE_BITS);

  // R2: without any write the stored control bits hold
  a_r2_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(int_wr_en) && !$past(ext_wr_en)) |->
      ($stable(persist) && $stable(port_sel) && $stable(io_tristate_n)));

  // R3: reserved control bits read back as zero on both ports
  a_r3_ext_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_rd_en) && $past(ext_addr) == ADDR_W'(A_CTRL)) |->
      ((ext_rdata & RSV) == '0));
  a_r3_int_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_rd_en) && $past(int_addr) == ADDR_W'(A_CTRL)) |->
      ((int_rdata & RSV) == '0));

  // R5: once decryption has been on, the key source is frozen
  a_r5_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (decrypt_en && $past(decrypt_en)) |-> $stable(key_src));

  // R6: the effective level moves only after the matching pulse
  a_r6_sec_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_level) |-> $past(enc_load ? load_done : startup_done));

  // R7: restricted external read returns zero and is rejected
  a_r7_read_block: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd_en && sec_level != 2'b00) |=> (ext_reject && ext_rdata == '0));

  // R8: locked level rejects every external write
  a_r8_write_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr_en && sec_level[1]) |=> ext_reject);

  // R10: no external access, no reject
  a_r10_no_spurious_rej: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_en && !ext_wr_en) |=> !ext_reject);
endmodule

bind cfgctl_reg cfgctl_reg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_rd_en     (ext_rd_en),
  .ext_wr_en     (ext_wr_en),
  .ext_addr      (ext_addr),
  .int_rd_en     (int_rd_en),
  .int_wr_en     (int_wr_en),
  .int_addr      (int_addr),
  .ext_rdata     (ext_rdata),
  .int_rdata     (int_rdata),
  .ext_reject    (ext_reject),
  .enc_load      (enc_load),
  .load_done     (load_done),
  .startup_done  (startup_done),
  .key_src       (key_src),
  .port_sel      (port_sel),
  .decrypt_en    (decrypt_en),
  .sec_level     (sec_level),
  .persist       (persist),
  .io_tristate_n (io_tristate_n)
);

// File: tb/tb_cfgctl_reg.sv
module tb_cfgctl_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] STORE = 32'hC000_1579;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_rd_en = 0, ext_wr_en = 0, int_rd_en = 0, int_wr_en = 0;
  logic [4:0]  ext_addr = 0, int_addr = 0;
  logic [31:0] ext_wdata = 0, int_wdata = 0;
  logic        enc_load = 0, load_done = 0, startup_done = 0;
  logic [31:0] ext_rdata, int_rdata;
  logic        ext_reject, key_src, port_sel, ot_shutdown_en, fallback_dis;
  logic        readback_mask_n, decrypt_en, persist, io_tristate_n;
  logic [1:0]  sec_level;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgctl_reg dut (
    .clk(clk), .rst_n(rst_n),
    .ext_rd_en(ext_rd_en), .ext_wr_en(ext_wr_en), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_reject(ext_reject),
    .int_rd_en(int_rd_en), .int_wr_en(int_wr_en), .int_addr(int_addr),
    .int_wdata(int_wdata), .int_rdata(int_rdata),
    .enc_load(enc_load), .load_done(load_done), .startup_done(startup_done),
    .key_src(key_src), .port_sel(port_sel), .ot_shutdown_en(ot_shutdown_en),
    .fallback_dis(fallback_dis), .readback_mask_n(readback_mask_n),
    .decrypt_en(decrypt_en), .sec_level(sec_level), .persist(persist),
    .io_tristate_n(io_tristate_n)
  );

  // behavioural reference model
  logic [31:0] m_ctrl, m_mask, m_erd, m_ird;
  logic        m_frz, m_klat, m_rej;
  logic [1:0]  m_sec;

  function automatic logic [31:0] regval(input logic [4:0] a);
    if (a == 5) return m_ctrl;
    if (a == 6) return m_mask;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h0000_0101; m_mask = 0; m_erd = 0; m_ird = 0;
      m_frz = 0; m_klat = 0; m_rej = 0; m_sec = 0;
    end else begin : upd
      logic rblk, wblk, hit;
      logic [4:0]  a;
      logic [31:0] d, wm, nc;
      rblk  = ext_rd_en && (m_sec != 0);
      wblk  = ext_wr_en && (m_sec[1] || (enc_load && !(ext_addr == 1 || ext_addr == 2)));
      m_rej = rblk || wblk;
      m_erd = (ext_rd_en && !rblk) ? regval(ext_addr) : 32'h0;
      m_ird = int_rd_en ? regval(int_addr) : 32'h0;
      if (enc_load ? load_done : startup_done) m_sec = m_ctrl[5:4];
      hit = 0; a = 0; d = 0;
      if (int_wr_en && (int_addr == 5 || int_addr == 6)) begin
        hit = 1; a = int_addr; d = int_wdata;
      end else if (ext_wr_en && !wblk && (ext_addr == 5 || ext_addr == 6)) begin
        hit = 1; a = ext_addr; d = ext_wdata;
      end
      if (hit) begin
        if (a == 6) m_mask = d;
        else begin
          wm = m_mask & STORE;
          nc = (m_ctrl & ~wm) | (d & wm);
          if (!m_frz && !m_ctrl[6] && nc[6]) begin m_frz = 1; m_klat = nc[31]; end
          m_ctrl = nc;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R12 ext_rdata", ext_rdata, m_erd);
    chk("R10 int_rdata", int_rdata, m_ird);
    chk("R7 ext_reject", 32'(ext_reject), 32'(m_rej));
    chk("R5 key_src", 32'(key_src), 32'(m_frz ? m_klat : m_ctrl[31]));
    chk("R4 port_sel", 32'(port_sel), 32'(m_ctrl[30]));
    chk("R4 ot_shutdown_en", 32'(ot_shutdown_en), 32'(m_ctrl[12]));
    chk("R4 fallback_dis", 32'(fallback_dis), 32'(m_ctrl[10]));
    chk("R4 readback_mask_n", 32'(readback_mask_n), 32'(m_ctrl[8]));
    chk("R4 decrypt_en", 32'(decrypt_en), 32'(m_ctrl[6]));
    chk("R4 persist", 32'(persist), 32'(m_ctrl[3]));
    chk("R4 io_tristate_n", 32'(io_tristate_n), 32'(m_ctrl[0]));
    chk("R6 sec_level", 32'(sec_level), 32'(m_sec));
  endtask

  task automatic idle();
    ext_rd_en = 0; ext_wr_en = 0; int_rd_en = 0; int_wr_en = 0;
    load_done = 0; startup_done = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle();
  endtask

  task automatic iwr(input logic [4:0] a, input logic [31:0] d);
    int_wr_en = 1; int_addr = a; int_wdata = d; tick();
  endtask
  task automatic ird(input logic [4:0] a);
    int_rd_en = 1; int_addr = a; tick();
  endtask
  task automatic ewr(input logic [4:0] a, input logic [31:0] d);
    ext_wr_en = 1; ext_addr = a; ext_wdata = d; tick();
  endtask
  task automatic erd(input logic [4:0] a);
    ext_rd_en = 1; ext_addr = a; tick();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk("R1 sec_level", 32'(sec_level), 0);
    chk("R1 io_tristate_n", 32'(io_tristate_n), 1);
    chk("R1 readback_mask_n", 32'(readback_mask_n), 1);
    chk("R1 ext_reject", 32'(ext_reject), 0);
    ird(5); chk("R1 ctrl reset", int_rdata, 32'h0000_0101);
    ird(6); chk("R1 mask reset", int_rdata, 32'h0);
    // R2 masked write
    iwr(6, 32'h0000_0008);
    iwr(5, 32'hFFFF_FFFF);
    ird(5); chk("R2 masked ctrl", int_rdata, 32'h0000_0109);
    // R3 reserved bits
    iwr(6, 32'hFFFF_FFFF);
    ewr(5, 32'hFFFF_FFFF);
    erd(5); chk("R3 storable only", ext_rdata, 32'hC000_1579);
    // R5 key frozen at 1
    iwr(5, 32'h0);
    chk("R5 key frozen", 32'(key_src), 1);
    ird(5); chk("R5 bit still writable", int_rdata, 32'h0);
    // R4 decode
    iwr(5, 32'h4000_1408);
    chk("R4 port_sel", 32'(port_sel), 1);
    chk("R4 ot_shutdown_en", 32'(ot_shutdown_en), 1);
    chk("R4 fallback_dis", 32'(fallback_dis), 1);
    chk("R4 persist", 32'(persist), 1);
    chk("R4 io_tristate_n", 32'(io_tristate_n), 0);
    chk("R4 readback_mask_n", 32'(readback_mask_n), 0);
    // R6 delayed security level
    iwr(5, 32'h0000_0011);
    chk("R6 pending not applied", 32'(sec_level), 0);
    enc_load = 1;
    startup_done = 1; tick();
    chk("R6 wrong event ignored", 32'(sec_level), 0);
    load_done = 1; tick();
    chk("R6 applied after load_done", 32'(sec_level), 1);
    // R7 readback blocked
    enc_load = 0;
    erd(5);
    chk("R7 reject", 32'(ext_reject), 1);
    chk("R7 zero data", ext_rdata, 0);
    ird(5); chk("R10 int read free", int_rdata, 32'h0000_0011);
    // R9 encrypted-load write filter
    enc_load = 1;
    ewr(5, 32'h0000_0021);
    chk("R9 ctrl write rejected", 32'(ext_reject), 1);
    ewr(1, 32'h1234);
    chk("R9 frame addr accepted", 32'(ext_reject), 0);
    ird(5); chk("R9 ctrl unchanged", int_rdata, 32'h0000_0011);
    enc_load = 0;
    ewr(5, 32'h0000_0021);
    startup_done = 1; tick();
    chk("R6 applied after startup_done", 32'(sec_level), 2);
    // R8 lock level
    ewr(1, 32'h5);
    chk("R8 frame write rejected", 32'(ext_reject), 1);
    ewr(5, 32'h0000_0001);
    chk("R8 ctrl write rejected", 32'(ext_reject), 1);
    ird(5); chk("R8 ctrl unchanged", int_rdata, 32'h0000_0021);
    iwr(5, 32'h0000_0001);
    ird(5); chk("R10 int write at lock", int_rdata, 32'h0000_0001);
    startup_done = 1; tick();
    chk("R6 lowered", 32'(sec_level), 0);
    // R11 collision
    int_wr_en = 1; int_addr = 5; int_wdata = 32'h0000_0109;
    ext_wr_en = 1; ext_addr = 5; ext_wdata = 32'h0000_0001; tick();
    ird(5); chk("R11 internal wins", int_rdata, 32'h0000_0109);
    int_wr_en = 1; int_addr = 6; int_wdata = 32'hFFFF_FFFF;
    ext_wr_en = 1; ext_addr = 5; ext_wdata = 32'h0; tick();
    ird(5); chk("R11 ext dropped", int_rdata, 32'h0000_0109);
    // R12 read ordering and unknown address
    int_wr_en = 1; int_addr = 5; int_wdata = 32'h0000_0001;
    ext_rd_en = 1; ext_addr = 5; tick();
    chk("R12 old value", ext_rdata, 32'h0000_0109);
    erd(7); chk("R12 unknown addr", ext_rdata, 0);
    // randomised traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] pick [5];
      pick[0] = 1; pick[1] = 2; pick[2] = 5; pick[3] = 6; pick[4] = 7;
      ext_rd_en = ($urandom_range(0, 2) == 0);
      ext_wr_en = ($urandom_range(0, 2) == 0);
      int_rd_en = ($urandom_range(0, 2) == 0);
      int_wr_en = ($urandom_range(0, 3) == 0);
      ext_addr  = pick[$urandom_range(0, 4)];
      int_addr  = pick[$urandom_range(0, 4)];
      ext_wdata = $urandom;
      int_wdata = $urandom;
      if ($urandom_range(0, 40) == 0) enc_load = ~enc_load;
      load_done    = ($urandom_range(0, 15) == 0);
      startup_done = ($urandom_range(0, 15) == 0);
      tick();
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule